// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block holds the alarm settings of a real-time clock and decides when the running time has reached them. There are six 8-bit alarm registers, one each for seconds, minutes, hours, weekday, day of month and month. Each register has its own compare-enable bit. A seventh register holds a two-digit BCD year alarm, and the comparison of that year is switched on by a bit in a control register. The timekeeping counters sit outside this block and present their BCD values on input ports, together with a one-cycle pulse for each counter update.

On an update pulse where every enabled field equals its counter, and the previous update did not already match, the block sets a sticky alarm flag. Software clears the flag by writing 0 to it. The interrupt output is the flag gated by an interrupt-enable bit. Registers are written through a simple single-cycle bus and read back combinationally. A power-on reset clears the enables and the control bits and leaves the alarm values as they were.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: Address map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year alarm (8 bits), 7 control. In registers 0 to 5, bit 7 is the compare enable and bits 6:0 hold the BCD value. A write stores the data and a read at the same address returns it.
- R2: Reserved bits read as 0 and are not stored. These are bit 6 of hours and day of month, bits 6:3 of weekday and bits 6:5 of month. Seconds and minutes use all of bits 6:0.
- R3: Control register: bit 0 is the alarm flag, bit 1 the interrupt enable and bit 2 the year-compare enable. Bits 7:3 read as 0.
- R4: A synchronous active-low reset clears all six compare enables, the flag, the interrupt enable and the year enable. Stored alarm values keep their contents through reset.
- R5: A match needs every enabled field to equal its counter. The counter is compared under the same bit mask as the register.
- R6: A field whose enable is 0 does not take part in the match, whatever its value.
- R7: The year alarm takes part only while the year-compare enable is 1.
- R8: When no enable is set (all six field enables and the year enable are 0), the flag is never set.
- R9: The match is evaluated only on a cycle with `tick` high. The flag is set one cycle after the first tick that matches. Consecutive matching ticks do not set it again once it has been cleared.
- R10: The flag stays set until a control write has bit 0 = 0. A write with bit 0 = 1 leaves the flag unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R11: `alarm_irq` equals the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tick | input | 1 | One-cycle pulse for each counter update |
| cnt_bcd | input | 48 | Current counters in BCD; byte i belongs to the field at address i |
| cnt_year | input | 8 | Current year counter in BCD, two digits |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
A wrong stored enable or value makes its own field match or miss wrongly. The error shows as a wrong `alarm_flag` one cycle after the next tick, and a register read shows it at once. A wrong previous-match bit shows as a missing flag or a repeated flag on the tick after a clear. A flag that is held or cleared wrongly shows on `alarm_irq` in the same cycle and on the control read-back.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and field masks for the alarm comparator.
package rtc_alarm_pkg;
    localparam int NFIELD    = 6;
    localparam int DW        = 8;
    localparam int VW        = DW - 1;
    localparam int AW        = 3;
    localparam logic [AW-1:0] ADDR_YEAR = 3'd6;
    localparam logic [AW-1:0] ADDR_CTRL = 3'd7;

    // Legal value bits of each field register (reserved bits are 0).
    function automatic logic [VW-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 7'h7F;
            2, 4:    field_mask = 7'h3F;
            3:       field_mask = 7'h07;
            5:       field_mask = 7'h1F;
            default: field_mask = 7'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
// Alarm register file: holds the per-field enables and values, the year value
// and the control bits. Assumes single-cycle writes. The enables and control
// bits are reset, the values are not. Reads are combinational.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int N = NFIELD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            flag,
    output logic [N-1:0]    en_vec,
    output logic [N*VW-1:0] val_flat,
    output logic [DW-1:0]   yr_val,
    output logic            yr_en,
    output logic            irq_en,
    output logic            clr,
    output logic [DW-1:0]   rdata
);
    for (genvar i = 0; i < N; i++) begin : g_field
        localparam logic [VW-1:0] MSK = field_mask(i);
        // Compare enable: cleared by power-on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                                en_vec[i] <= 1'b0;
            else if (wr && addr == AW'(i))             en_vec[i] <= wdata[DW-1];
        end
        // Alarm value: kept through reset, reserved bits dropped.
        always_ff @(posedge clk) begin
            if (wr && addr == AW'(i)) val_flat[i*VW +: VW] <= wdata[VW-1:0] & MSK;
        end
    end

    // Year alarm value: kept through reset.
    always_ff @(posedge clk) begin
        if (wr && addr == ADDR_YEAR) yr_val <= wdata;
    end

    // Control enables: cleared by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            yr_en  <= 1'b0;
        end else if (wr && addr == ADDR_CTRL) begin
            irq_en <= wdata[1];
            yr_en  <= wdata[2];
        end
    end

    // Flag clear request: a control write with bit 0 low.
    assign clr = wr && (addr == ADDR_CTRL) && !wdata[0];

    // Read mux.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (addr == AW'(i)) rdata = {en_vec[i], val_flat[i*VW +: VW]};
        if (addr == ADDR_YEAR) rdata = yr_val;
        if (addr == ADDR_CTRL) rdata = {5'b0, yr_en, irq_en, flag};
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Match logic: the alarm matches when at least one compare is enabled and
// every enabled field equals its masked counter. Purely combinational.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int N = NFIELD
) (
    input  logic [N-1:0]    en_vec,
    input  logic [N*VW-1:0] val_flat,
    input  logic            yr_en,
    input  logic [DW-1:0]   yr_val,
    input  logic [N*DW-1:0] cnt_bcd,
    input  logic [DW-1:0]   cnt_year,
    output logic            match
);
    logic [N-1:0] ok;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic [DW-1:0] MSK = {1'b0, field_mask(i)};
        // Per-field result: true when disabled or equal.
        assign ok[i] = !en_vec[i] ||
                       ({1'b0, val_flat[i*VW +: VW]} == (cnt_bcd[i*DW +: DW] & MSK));
    end

    logic yr_ok, any_en;
    assign yr_ok  = !yr_en || (yr_val == cnt_year);
    assign any_en = (|en_vec) || yr_en;
    assign match  = any_en && (&ok) && yr_ok;
endmodule

// File: rtl/rtc_alarm_flag.sv
// Alarm flag: sets on the first matching tick and clears on a software write.
// Assumes tick is one cycle wide. A set takes priority over a clear.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic clr,
    output logic flag
);
    logic prev_match;

    // Match state at the last tick, used to find the first matching tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_match <= 1'b0;
        else if (tick) prev_match <= match;
    end

    // Sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag <= 1'b0;
        else if (tick && match && !prev_match) flag <= 1'b1;
        else if (clr)                          flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Top of the alarm comparator: register file, match logic and flag.
// Assumes the counters are stable in the cycle that tick is high.
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic               tick,
    input  logic [NFIELD*DW-1:0] cnt_bcd,
    input  logic [DW-1:0]      cnt_year,
    output logic               alarm_flag,
    output logic               alarm_irq
);
    logic [NFIELD-1:0]    en_vec;
    logic [NFIELD*VW-1:0] val_flat;
    logic [DW-1:0]        yr_val;
    logic                 yr_en, irq_en, clr, match;

    rtc_alarm_regs #(.N(NFIELD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .flag(alarm_flag), .en_vec(en_vec), .val_flat(val_flat), .yr_val(yr_val),
        .yr_en(yr_en), .irq_en(irq_en), .clr(clr), .rdata(bus_rdata)
    );

    rtc_alarm_match #(.N(NFIELD)) u_match (
        .en_vec(en_vec), .val_flat(val_flat), .yr_en(yr_en), .yr_val(yr_val),
        .cnt_bcd(cnt_bcd), .cnt_year(cnt_year), .match(match)
    );

    rtc_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(match), .clr(clr),
        .flag(alarm_flag)
    );

    // Interrupt request: flag gated by its enable.
    assign alarm_irq = alarm_flag & irq_en;
endmodule

// File: rtl/rtc_alarm_chk.sv
// Assertion checker bound to the alarm comparator top.
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              tick,
    input logic [NFIELD-1:0] en_vec,
    input logic              yr_en,
    input logic              alarm_flag,
    input logic              alarm_irq
);
    // R11
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag);
    // R9
    flag_set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick));
    // R8
    flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past((|en_vec) || yr_en));
    // R10
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(bus_wr && bus_addr == ADDR_CTRL && !bus_wdata[0]));
    // R2
    hour_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd2) |-> !bus_rdata[6]);
    // R3
    ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[7:3] == 5'b0));
endmodule

bind rtc_alarm_cmp rtc_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .en_vec(en_vec), .yr_en(yr_en), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
);

// File: tb/rtc_alarm_cmp_bench.sv
module rtc_alarm_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tick = 1'b0;
    logic [47:0] cnt_bcd = '0;
    logic [7:0]  cnt_year = '0;
    logic        alarm_flag, alarm_irq;

    int n_run = 0;
    int n_fail = 0;

    // Model state.
    logic [6:0] m_val [6];
    logic [5:0] m_en;
    logic [7:0] m_yr;
    logic       m_yren, m_irqen, m_flag, m_prev;

    rtc_alarm_cmp u_rtc_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .cnt_bcd(cnt_bcd), .cnt_year(cnt_year),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [6:0] msk(input int i);
        case (i)
            0, 1:    return 7'h7F;
            2, 4:    return 7'h3F;
            3:       return 7'h07;
            default: return 7'h1F;
        endcase
    endfunction

    function automatic logic exp_match();
        logic ok;
        ok = (m_en != 0) || m_yren;
        for (int i = 0; i < 6; i++)
            if (m_en[i] && ((cnt_bcd[i*8 +: 7] & msk(i)) != m_val[i])) ok = 0;
        if (m_yren && cnt_year != m_yr) ok = 0;
        return ok;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        if (a < 6) begin m_en[a] = d[7]; m_val[a] = d[6:0] & msk(int'(a)); end
        else if (a == 6) m_yr = d;
        else begin m_irqen = d[1]; m_yren = d[2]; if (!d[0]) m_flag = 0; end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic do_tick(input string req);
        logic m;
        @(negedge clk);
        m = exp_match();
        tick = 1;
        @(negedge clk);
        tick = 0;
        if (m && !m_prev) m_flag = 1;
        m_prev = m;
        check(req, alarm_flag, m_flag);
        check("R11", alarm_irq, m_flag & m_irqen);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_en = 0; m_yren = 0; m_irqen = 0; m_flag = 0; m_prev = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        check("R4", alarm_flag, 0);
        check("R4", alarm_irq, 0);
        rd_chk("R4", 3'd7, 8'h00);

        // R1 / R2: store and read back with reserved bits masked.
        for (int i = 0; i < 6; i++) begin
            wr(3'(i), 8'hFF);
            rd_chk(i < 2 ? "R1" : "R2", 3'(i), {1'b1, msk(i)});
        end
        wr(3'd6, 8'h24);
        rd_chk("R1", 3'd6, 8'h24);
        wr(3'd7, 8'hFE);
        rd_chk("R3", 3'd7, 8'h06);

        // R4: values survive reset, enables clear.
        for (int i = 0; i < 6; i++) wr(3'(i), {1'b1, 7'(8'h11 + i)});
        do_reset();
        for (int i = 0; i < 6; i++) rd_chk("R4", 3'(i), {1'b0, 7'(8'h11 + i) & msk(i)});
        rd_chk("R4", 3'd6, 8'h24);

        // R8: nothing enabled, counters equal to values, no alarm.
        for (int i = 0; i < 6; i++) cnt_bcd[i*8 +: 8] = {1'b0, m_val[i]};
        cnt_year = m_yr;
        do_tick("R8");

        // R5 / R9: hour only, matching tick sets flag, held while matching.
        wr(3'd2, 8'h80 | 8'h23);
        wr(3'd7, 8'h03);
        cnt_bcd[16 +: 8] = 8'h23;
        do_tick("R9");
        check("R9", alarm_flag, 1);
        wr(3'd7, 8'h03);                      // R10: bit0=1 keeps flag
        check("R10", alarm_flag, 1);
        wr(3'd7, 8'h02);                      // R10: clear
        check("R10", alarm_flag, 0);
        do_tick("R9");                         // still matching: no re-set
        check("R9", alarm_flag, 0);
        cnt_bcd[16 +: 8] = 8'h22;
        do_tick("R5");
        cnt_bcd[16 +: 8] = 8'h23;
        cnt_bcd[0 +: 8] = 8'h59;               // R6: seconds disabled, differs
        do_tick("R6");
        check("R6", alarm_flag, 1);
        wr(3'd7, 8'h02);

        // R7: year enable with mismatching year blocks the alarm.
        cnt_bcd[16 +: 8] = 8'h01;
        do_tick("R5");
        wr(3'd6, 8'h30);
        cnt_year = 8'h31;
        wr(3'd7, 8'h06);
        cnt_bcd[16 +: 8] = 8'h23;
        do_tick("R7");
        check("R7", alarm_flag, 0);
        cnt_year = 8'h30;
        do_tick("R7");
        check("R7", alarm_flag, 1);

        // R9: no tick, no update even when match newly true.
        wr(3'd7, 8'h06);
        @(negedge clk);
        check("R9", alarm_flag, m_flag);

        // Random mix.
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 2) wr(3'($urandom_range(0, 5)), 8'($urandom));
            else if (sel == 2) wr(3'd7, 8'($urandom) & 8'h07);
            else if (sel == 3) wr(3'd6, 8'($urandom));
            else begin
                for (int i = 0; i < 6; i++)
                    cnt_bcd[i*8 +: 8] = ($urandom_range(0, 3) != 0) ? {1'b0, m_val[i]} : 8'($urandom);
                cnt_year = ($urandom_range(0, 3) != 0) ? m_yr : 8'($urandom);
                do_tick("R5");
            end
            if (it % 50 == 0) rd_chk("R3", 3'd7, {5'b0, m_yren, m_irqen, m_flag});
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #5_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule